// File: doc/BRIEF.md
# Multi-Mode Timer with Variable-Length PWM

This block is a 16-bit timer built from two 8-bit counter halves. A 2-bit mode input selects how the halves are used. The halves can run as two separate 8-bit timers. The low half can run as a timer while the high half acts as an 8-bit PWM. The two halves can chain into one 16-bit timer. Finally, they can form a PWM whose period is 2^N counts, with N set anywhere from 9 to 16. Each timer wraps at a programmable limit and raises a one-clock overflow pulse. The PWM output is high for the first `duty` counts of each period.

The clock `clk_i` runs at twice the count-cycle rate. In the two narrow modes, the counters advance on every second clock. In the two wide modes, `fast_i` doubles the rate so the counters advance on every clock. Limits, duty and length come in as plain inputs, so a surrounding register file drives them. A duty value is captured only when a new period starts.

Top module: `multi_mode_timer`

## Requirements
- R1: After reset `pwm_o`, `lo_ovf_o` and `hi_ovf_o` are low.
- R2: Mode 0 (`mode_i`=0) runs two independent 8-bit timers. The low timer is enabled by `run_lo_i` and the high timer by `run_hi_i`. A half with limit L overflows every L+1 counts and pulses `lo_ovf_o` or `hi_ovf_o` for one clock. A stopped half produces no pulses.
- R3: Mode 1 runs the low half as a timer, as in mode 0. The high half, enabled by `run_hi_i`, is a PWM with a period of 256 counts. Its output is high for `duty_i[7:0]` counts per period. `hi_ovf_o` pulses once per period.
- R4: Mode 2 chains the halves into one timer enabled by `run_lo_i`. Its period is H*256+L+1 counts, where H is `hi_lim_i` and L is `lo_lim_i`. `hi_ovf_o` pulses once per period and `lo_ovf_o` stays low.
- R5: Mode 3 is a PWM enabled by `run_lo_i`. Its period is 2^(9+`len_i`) counts. The output is high while the count is below `duty_i`, so a duty value at or above the period gives a constant high. `hi_ovf_o` pulses once per period.
- R6: One count lasts two clocks in modes 0 and 1, whatever the value of `fast_i`. In modes 2 and 3, one count lasts two clocks when `fast_i`=0 and one clock when `fast_i`=1.
- R7: A change on `duty_i` during a PWM period does not alter that period. It takes effect from the next period.
- R8: `pwm_o` stays low in modes 0 and 2. It also stays low whenever the PWM half of the current mode is stopped.
- R9: Stopping a timer clears its count. After a restart in mode 2 with `fast_i`=1, the first `hi_ovf_o` pulse comes exactly one full period (in clocks) after the enable is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, twice the count-cycle rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 dual timer, 1 timer+PWM8, 2 wide timer, 3 variable PWM |
| fast_i | input | 1 | Half-cycle count rate in modes 2 and 3 |
| run_lo_i | input | 1 | Run low half (whole counter in modes 2 and 3) |
| run_hi_i | input | 1 | Run high half in modes 0 and 1 |
| lo_lim_i | input | 8 | Low half limit |
| hi_lim_i | input | 8 | High half limit |
| len_i | input | 3 | PWM length N-9 in mode 3 |
| duty_i | input | 16 | PWM duty (low 8 bits in mode 1) |
| pwm_o | output | 1 | PWM output |
| lo_ovf_o | output | 1 | Low timer overflow pulse |
| hi_ovf_o | output | 1 | High or wide overflow pulse |

## Verification
In mode 0 the two halves can overflow in the same clock. The bench provokes this by giving both halves the same limit and raising both enables on one edge. It then checks over many periods that `lo_ovf_o` and `hi_ovf_o` never differ in any clock. In mode 3, a duty update can land in the middle of a period. The bench writes a larger duty mid-period and checks two things: the high time of that period matches the old duty, and the high time of the following period matches the new one. Period and high-time measurements use the overflow pulses as frame marks, so the internal phase of the count strobe never needs to be known.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL    = 2'd0,
    MODE_TMR_PWM = 2'd1,
    MODE_WIDE    = 2'd2,
    MODE_VARPWM  = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_i,
  output logic tick_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  // fast: enable every clock (two per count cycle)
  assign tick_o = fast_i | phase_q;
endmodule

// File: rtl/tmr_half.sv
module tmr_half #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = en_i && !clr_i && (cnt_q == top_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + W'(1);
  end

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0)); // R9
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && cnt_o != top_i) |=> (cnt_o == $past(cnt_o) + W'(1))); // R2
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         active_i,
  input  logic         wrap_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] duty_i,
  output logic         pwm_o
);
  logic [W-1:0] duty_q;

  // duty captured while idle and at each period boundary only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  duty_q <= '0;
    else if (!active_i || wrap_i) duty_q <= duty_i;
  end

  assign pwm_o = active_i && (cnt_i < duty_q);

  AST_DUTY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !wrap_i) |=> $stable(duty_q)); // R7
endmodule

// File: rtl/multi_mode_timer.sv
module multi_mode_timer #(
  parameter int HALF_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            mode_i,
  input  logic                  fast_i,
  input  logic                  run_lo_i,
  input  logic                  run_hi_i,
  input  logic [HALF_W-1:0]     lo_lim_i,
  input  logic [HALF_W-1:0]     hi_lim_i,
  input  logic [LEN_W-1:0]      len_i,
  input  logic [2*HALF_W-1:0]   duty_i,
  output logic                  pwm_o,
  output logic                  lo_ovf_o,
  output logic                  hi_ovf_o
);
  import tmr_pkg::*;
  localparam int CNT_W = 2 * HALF_W;

  tmr_mode_e mode;
  logic wide, tick;
  logic lo_clr, lo_en, lo_wrap, hi_clr, hi_en, hi_wrap;
  logic [HALF_W-1:0] lo_cnt, hi_cnt, lo_top, hi_top, hi_mask;
  logic pwm_act;
  logic [CNT_W-1:0] pwm_cnt, pwm_duty;
  logic lo_ovf_q, hi_ovf_q;

  assign mode = tmr_mode_e'(mode_i);
  assign wide = (mode == MODE_WIDE) || (mode == MODE_VARPWM);

  tmr_tick_gen u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fast_i (fast_i & wide),
    .tick_o (tick)
  );

  // high-half top for length N = HALF_W+1+len
  always_comb begin
    hi_mask = '0;
    for (int i = 0; i < HALF_W; i++) hi_mask[i] = (i <= int'(len_i));
  end

  always_comb begin
    unique case (mode)
      MODE_DUAL:    hi_top = hi_lim_i;
      MODE_TMR_PWM: hi_top = '1;
      MODE_WIDE:    hi_top = hi_lim_i;
      default:      hi_top = hi_mask;
    endcase
    unique case (mode)
      MODE_WIDE:    lo_top = (hi_cnt == hi_top) ? lo_lim_i : '1;
      MODE_VARPWM:  lo_top = '1;
      default:      lo_top = lo_lim_i;
    endcase
  end

  assign lo_clr = ~run_lo_i;
  assign lo_en  = tick & run_lo_i;
  assign hi_clr = wide ? ~run_lo_i : ~run_hi_i;
  assign hi_en  = wide ? (tick & run_lo_i & lo_wrap) : (tick & run_hi_i);

  tmr_half #(.W(HALF_W)) u_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (lo_clr),
    .en_i   (lo_en),
    .top_i  (lo_top),
    .cnt_o  (lo_cnt),
    .wrap_o (lo_wrap)
  );

  tmr_half #(.W(HALF_W)) u_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (hi_clr),
    .en_i   (hi_en),
    .top_i  (hi_top),
    .cnt_o  (hi_cnt),
    .wrap_o (hi_wrap)
  );

  assign pwm_act  = ((mode == MODE_TMR_PWM) && run_hi_i) ||
                    ((mode == MODE_VARPWM) && run_lo_i);
  assign pwm_cnt  = (mode == MODE_VARPWM) ? {hi_cnt, lo_cnt}
                                          : {{HALF_W{1'b0}}, hi_cnt};
  assign pwm_duty = (mode == MODE_VARPWM) ? duty_i
                                          : {{HALF_W{1'b0}}, duty_i[HALF_W-1:0]};

  tmr_pwm #(.W(CNT_W)) u_pwm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (pwm_act),
    .wrap_i   (hi_wrap),
    .cnt_i    (pwm_cnt),
    .duty_i   (pwm_duty),
    .pwm_o    (pwm_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_ovf_q <= 1'b0;
      hi_ovf_q <= 1'b0;
    end else begin
      lo_ovf_q <= lo_wrap & ~wide;
      hi_ovf_q <= hi_wrap;
    end
  end

  assign lo_ovf_o = lo_ovf_q;
  assign hi_ovf_o = hi_ovf_q;

  AST_PWM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_o |-> ((mode_i == 2'd1 && run_hi_i) || (mode_i == 2'd3 && run_lo_i))); // R8
  AST_HI_OVF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_ovf_o |-> (hi_cnt == '0)); // R2
  AST_LO_OVF_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_ovf_o |=> !lo_ovf_o); // R6
endmodule

// File: tb/sim_multi_mode_timer.sv
module sim_multi_mode_timer;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] mode_i = '0;
  logic fast_i = 1'b0, run_lo_i = 1'b0, run_hi_i = 1'b0;
  logic [7:0] lo_lim_i = '0, hi_lim_i = '0;
  logic [2:0] len_i = '0;
  logic [15:0] duty_i = '0;
  logic pwm_o, lo_ovf_o, hi_ovf_o;

  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  multi_mode_timer u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  function automatic int wide_period(input int h, input int l, input bit f);
    return (h * 256 + l + 1) * (f ? 1 : 2);
  endfunction

  function automatic int var_high(input int len, input int d, input bit f);
    int p = 1 << (9 + len);
    return ((d > p) ? p : d) * (f ? 1 : 2);
  endfunction

  function automatic bit ovf_sel(input bit use_hi);
    return use_hi ? hi_ovf_o : lo_ovf_o;
  endfunction

  // assumes current negedge shows an overflow pulse
  task automatic measure_here(input bit use_hi, output int clks, output int highs,
                              output int lo_pulses);
    clks = 0; highs = 0; lo_pulses = 0;
    do begin
      if (pwm_o) highs++;
      if (lo_ovf_o) lo_pulses++;
      clks++;
      @(negedge clk_i);
    end while (!ovf_sel(use_hi) && clks < 150000);
  endtask

  task automatic sync(input bit use_hi);
    int n = 0;
    do begin @(negedge clk_i); n++; end while (!ovf_sel(use_hi) && n < 150000);
  endtask

  task automatic measure(input bit use_hi, output int clks, output int highs,
                         output int lo_pulses);
    sync(use_hi);
    measure_here(use_hi, clks, highs, lo_pulses);
  endtask

  task automatic stop_all();
    @(negedge clk_i);
    run_lo_i = 1'b0; run_hi_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    int c, h, lp, n, mis, pl, ph;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 pwm", pwm_o, 0);
    check("R1 lo_ovf", lo_ovf_o, 0);
    check("R1 hi_ovf", hi_ovf_o, 0);

    // R2 dual timers
    mode_i = 2'd0; lo_lim_i = 8'd4; hi_lim_i = 8'd9; duty_i = 16'hFFFF;
    run_lo_i = 1'b1; run_hi_i = 1'b1;
    measure(1'b0, c, h, lp); check("R2 lo period", c, 10);
    measure(1'b1, c, h, lp); check("R2 hi period", c, 20);
    check("R8 mode0 pwm high count", h, 0);
    stop_all();
    for (int k = 0; k < 4; k++) begin
      int ll = $urandom % 40, hl = $urandom % 40;
      lo_lim_i = 8'(ll); hi_lim_i = 8'(hl);
      run_lo_i = 1'b1; run_hi_i = 1'b1;
      measure(1'b0, c, h, lp); check("R2 rand lo period", c, 2 * (ll + 1));
      measure(1'b1, c, h, lp); check("R2 rand hi period", c, 2 * (hl + 1));
      stop_all();
    end
    // same-cycle overflow of both halves
    lo_lim_i = 8'd7; hi_lim_i = 8'd7;
    @(negedge clk_i); run_lo_i = 1'b1; run_hi_i = 1'b1;
    mis = 0; pl = 0; ph = 0;
    for (int i = 0; i < 160; i++) begin
      @(negedge clk_i);
      if (lo_ovf_o != hi_ovf_o) mis++;
      pl += lo_ovf_o; ph += hi_ovf_o;
    end
    check("R2 coincident overflow mismatches", mis, 0);
    check("R2 coincident pulse counts", pl, ph);
    check("R2 pulses seen", (pl >= 9) ? 1 : 0, 1);
    run_hi_i = 1'b0;
    ph = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk_i); ph += hi_ovf_o; end
    check("R2 stopped half silent", ph, 0);
    // R6 fast ignored in narrow mode
    fast_i = 1'b1;
    measure(1'b0, c, h, lp); check("R6 mode0 fast ignored", c, 16);
    stop_all();

    // R3 timer + 8-bit PWM
    mode_i = 2'd1; lo_lim_i = 8'd5; duty_i = 16'hFF40;
    run_lo_i = 1'b1; run_hi_i = 1'b1;
    measure(1'b1, c, h, lp);
    check("R3 pwm8 period", c, 512);
    check("R3 pwm8 high", h, 128);
    check("R6 mode1 fast ignored", c, 512);
    measure(1'b0, c, h, lp); check("R3 low timer period", c, 12);
    for (int k = 0; k < 3; k++) begin
      int d = $urandom % 256;
      stop_all();
      duty_i = 16'(d);
      run_lo_i = 1'b1; run_hi_i = 1'b1;
      measure(1'b1, c, h, lp); check("R3 rand pwm8 high", h, 2 * d);
    end
    // R8 pwm half stopped
    run_hi_i = 1'b0; duty_i = 16'h00FF;
    n = 0;
    for (int i = 0; i < 600; i++) begin @(negedge clk_i); n += pwm_o; end
    check("R8 mode1 stopped pwm", n, 0);
    stop_all();

    // R4 wide timer
    mode_i = 2'd2; fast_i = 1'b0; hi_lim_i = 8'd1; lo_lim_i = 8'd3; duty_i = 16'hFFFF;
    run_lo_i = 1'b1;
    measure(1'b1, c, h, lp);
    check("R4 wide period", c, wide_period(1, 3, 1'b0));
    check("R4 lo_ovf silent", lp, 0);
    check("R8 mode2 pwm", h, 0);
    for (int k = 0; k < 4; k++) begin
      int hh = $urandom % 3, ll = $urandom % 256;
      bit ff = 1'($urandom % 2);
      stop_all();
      hi_lim_i = 8'(hh); lo_lim_i = 8'(ll); fast_i = ff;
      run_lo_i = 1'b1;
      measure(1'b1, c, h, lp); check("R4 R6 rand wide period", c, wide_period(hh, ll, ff));
    end
    // R9 restart from zero
    stop_all();
    fast_i = 1'b1; hi_lim_i = 8'd0; lo_lim_i = 8'd20;
    run_lo_i = 1'b1;
    n = 0;
    do begin @(negedge clk_i); n++; end while (!hi_ovf_o && n < 1000);
    check("R9 first overflow after restart", n, 21);
    stop_all();

    // R5 variable PWM
    mode_i = 2'd3; len_i = 3'd0; fast_i = 1'b0; duty_i = 16'd100;
    run_lo_i = 1'b1;
    measure(1'b1, c, h, lp);
    check("R5 N9 period", c, 1024);
    check("R5 N9 high", h, var_high(0, 100, 1'b0));
    stop_all();
    len_i = 3'd1; fast_i = 1'b1; duty_i = 16'd300; run_lo_i = 1'b1;
    measure(1'b1, c, h, lp);
    check("R5 R6 N10 fast period", c, 1024);
    check("R5 N10 fast high", h, var_high(1, 300, 1'b1));
    stop_all();
    len_i = 3'd0; duty_i = 16'd600; run_lo_i = 1'b1;
    measure(1'b1, c, h, lp); check("R5 duty above period", h, 512);
    stop_all();
    duty_i = 16'd0; run_lo_i = 1'b1;
    measure(1'b1, c, h, lp); check("R5 duty zero", h, 0);
    stop_all();
    len_i = 3'd2; fast_i = 1'b0; duty_i = 16'd1000; run_lo_i = 1'b1;
    measure(1'b1, c, h, lp);
    check("R5 N11 period", c, 4096);
    check("R5 N11 high", h, 2000);
    for (int k = 0; k < 3; k++) begin
      int d = $urandom % 560;
      stop_all();
      len_i = 3'd0; fast_i = 1'b1; duty_i = 16'(d); run_lo_i = 1'b1;
      measure(1'b1, c, h, lp); check("R5 rand N9 high", h, var_high(0, d, 1'b1));
    end
    // R8 stopped in mode 3
    stop_all();
    duty_i = 16'hFFFF;
    n = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk_i); n += pwm_o; end
    check("R8 mode3 stopped pwm", n, 0);

    // R7 duty applied at next period
    len_i = 3'd0; fast_i = 1'b0; duty_i = 16'd100; run_lo_i = 1'b1;
    sync(1'b1);
    c = 0; h = 0;
    do begin
      if (pwm_o) h++;
      c++;
      if (c == 300) duty_i = 16'd400;
      @(negedge clk_i);
    end while (!hi_ovf_o && c < 150000);
    check("R7 old duty kept", h, 200);
    measure_here(1'b1, c, h, lp);
    check("R7 new duty next period", h, 800);
    stop_all();

    summary();
  end
endmodule